// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the processor-side register file of a four-channel legacy DMA engine. Software programs it through an 8-bit I/O port. One command address takes a shared channel-mode byte, and its low two bits name the channel that receives the upper six bits. A second command address returns the byte pointer to its initial state, whatever data is written. A third address performs a master clear. Each channel owns a 16-bit address register and a 16-bit word-count register. Both have a base copy and a current copy, and both are reached one byte at a time through the single byte pointer. Reads and writes share that pointer.

Alongside the programming path, the block keeps each channel's current address and count up to date as transfers are acknowledged. The address steps up or down, the count runs down, and a terminal-count flag is raised when the count wraps. With autoinitialize on, the current copies are reloaded from the base copies at that moment and the channel keeps running. With autoinitialize off, the channel stops. The block also decodes each channel's transfer direction from its mode bits.

Register offsets: channel c address at 2c, channel c count at 2c+1, mode at `MODE_OFS` (default 0xB), pointer clear at `CLRPTR_OFS` (0xC), master clear at `MCLR_OFS` (0xD).

Top module: `dmaChanRegs`

## Requirements
- R1: A mode write stores data bits 7:2 into the channel named by data bits 1:0, and into no other channel. `chanModes[6c+5:6c]` shows channel c as {mode[1:0], decrement, autoinit, type[1:0]}. All channels read zero after reset.
- R2: Any write to the pointer-clear address, whatever its data, makes the next 16-bit register access hit the low byte.
- R3: Each read or write of any channel address or count register toggles the one shared byte pointer: low byte, then high byte, then low again.
- R4: Writing a byte of an address or count register loads that byte into both the base and the current copy. A read returns the current copy.
- R5: On `xferAck` for channel `xferChan`, the current address moves by +1 when mode bit 3 (the decrement bit) is 0 and by -1 when it is 1. The current count drops by 1 in either case.
- R6: When the count wraps from 0x0000 to 0xFFFF, `tcFlags` for that channel is set. If autoinit (mode bit 2) is clear, later acknowledges have no effect on that channel.
- R7: If autoinit is set, the acknowledge that wraps the count loads the current address and count from their base copies instead. It also sets the flag, and the channel keeps stepping on later acknowledges.
- R8: A write to the master-clear address zeroes every channel's mode bits and every terminal-count flag, and clears the byte pointer, all at one clock edge. The address and count registers are left unchanged.
- R9: `chanToMem[c]` is 1 only for type 01, and `chanFromMem[c]` only for type 10. Both are 0 for types 00 and 11, and for every type when the mode field is 11 (cascade).
- R10: A channel in cascade mode ignores acknowledges: its registers and flag do not change.
- R11: Writing either byte of a channel's count register clears that channel's terminal-count flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | I/O write strobe, one cycle per byte |
| ioRd | input | 1 | I/O read strobe, one cycle per byte |
| ioAddr | input | ADDR_W | Register offset |
| ioWrData | input | 8 | Write data byte |
| ioRdData | output | 8 | Read data byte, valid while ioRd is high |
| xferAck | input | 1 | One transfer completed on xferChan |
| xferChan | input | 2 | Channel of the acknowledged transfer |
| chanModes | output | 24 | Stored mode bits, 6 per channel |
| tcFlags | output | 4 | Terminal-count flag per channel |
| chanToMem | output | 4 | Channel moves data from I/O into memory |
| chanFromMem | output | 4 | Channel moves data from memory out to I/O |

## Verification
The bench builds the block with its default parameters: a 4-bit offset and command ports at 0xB, 0xC and 0xD. That puts all four channels' address and count registers and all three command ports in reach of one test. Small programmed counts let each channel hit terminal count within a few acknowledges. Both directions, both autoinit settings, cascade and the illegal type are each run on a separate channel, so their results can be told apart at the ports.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int NUM_CH = 4;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int MODE_W = 6;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    XFER_DEMAND  = 2'b00,
    XFER_SINGLE  = 2'b01,
    XFER_RSVD    = 2'b10,
    XFER_CASCADE = 2'b11
  } xferMode_e;

  typedef enum logic [1:0] {
    TT_VERIFY  = 2'b00,
    TT_TOMEM   = 2'b01,
    TT_FROMMEM = 2'b10,
    TT_ILLEGAL = 2'b11
  } xferType_e;

  typedef struct packed {
    logic            modeWr;
    logic            masterClr;
    logic            regWr;
    logic            regRd;
    logic            isCount;
    logic            hiByte;
    logic [CH_W-1:0] chan;
  } dmaStrobe_t;
endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaRegPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] MODE_OFS = 'hB,
  parameter logic [ADDR_W-1:0] CLRPTR_OFS = 'hC,
  parameter logic [ADDR_W-1:0] MCLR_OFS = 'hD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  output dmaStrobe_t        stb,
  output logic              bytePtr
);
  localparam logic [ADDR_W-1:0] REG_SPAN = ADDR_W'(2 * NUM_CH);

  logic isReg;
  logic regAccess;
  logic ptrClr;

  assign isReg     = ioAddr < REG_SPAN;
  assign regAccess = (ioWr || ioRd) && isReg;
  assign ptrClr    = ioWr && (ioAddr == CLRPTR_OFS);

  always_comb begin
    stb.modeWr    = ioWr && (ioAddr == MODE_OFS);
    stb.masterClr = ioWr && (ioAddr == MCLR_OFS);
    stb.regWr     = ioWr && isReg;
    stb.regRd     = ioRd && isReg;
    stb.isCount   = ioAddr[0];
    stb.hiByte    = bytePtr;
    stb.chan      = ioAddr[CH_W:1];
  end

  // shared low/high byte pointer
  always_ff @(posedge clk) begin
    if (!rstN) bytePtr <= 1'b0;
    else if (ptrClr || stb.masterClr) bytePtr <= 1'b0;
    else if (regAccess) bytePtr <= ~bytePtr;
  end
endmodule

// File: rtl/dmaRegData.sv
module dmaRegData
  import dmaRegPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  dmaStrobe_t               stb,
  input  logic [7:0]               ioWrData,
  input  logic                     xferAck,
  input  logic [CH_W-1:0]          xferChan,
  output logic [7:0]               ioRdData,
  output logic [NUM_CH*MODE_W-1:0] chanModes,
  output logic [NUM_CH-1:0]        tcFlags,
  output logic [NUM_CH-1:0]        chanToMem,
  output logic [NUM_CH-1:0]        chanFromMem
);
  logic [REG_W-1:0] curAddrArr [NUM_CH];
  logic [REG_W-1:0] curCntArr  [NUM_CH];

  function automatic logic [REG_W-1:0] putByte(logic [REG_W-1:0] v, logic hi, logic [7:0] d);
    logic [REG_W-1:0] r;
    r = v;
    if (hi) r[15:8] = d;
    else    r[7:0]  = d;
    return r;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [MODE_W-1:0] modeQ;
    logic [REG_W-1:0]  baseAddr, curAddr, baseCnt, curCnt;
    logic              tcQ;
    logic              selCh, wrAddrHere, wrCntHere;
    logic              isCascade, autoOn, decr, stepOk, atWrap;

    assign selCh      = stb.chan == CH_W'(c);
    assign wrAddrHere = stb.regWr && selCh && !stb.isCount;
    assign wrCntHere  = stb.regWr && selCh && stb.isCount;
    assign isCascade  = xferMode_e'(modeQ[5:4]) == XFER_CASCADE;
    assign decr       = modeQ[3];
    assign autoOn     = modeQ[2];
    assign stepOk     = xferAck && (xferChan == CH_W'(c)) && !(stb.regWr && selCh)
                        && !isCascade && !(tcQ && !autoOn);
    assign atWrap     = curCnt == '0;

    always_ff @(posedge clk) begin
      if (!rstN) modeQ <= '0;
      else if (stb.masterClr) modeQ <= '0;
      else if (stb.modeWr && ioWrData[CH_W-1:0] == CH_W'(c)) modeQ <= ioWrData[7:2];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseAddr <= '0;
        curAddr  <= '0;
      end else if (wrAddrHere) begin
        baseAddr <= putByte(baseAddr, stb.hiByte, ioWrData);
        curAddr  <= putByte(curAddr, stb.hiByte, ioWrData);
      end else if (stepOk) begin
        if (atWrap && autoOn) curAddr <= baseAddr;
        else if (decr)        curAddr <= curAddr - 1'b1;
        else                  curAddr <= curAddr + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseCnt <= '0;
        curCnt  <= '0;
      end else if (wrCntHere) begin
        baseCnt <= putByte(baseCnt, stb.hiByte, ioWrData);
        curCnt  <= putByte(curCnt, stb.hiByte, ioWrData);
      end else if (stepOk) begin
        if (atWrap && autoOn) curCnt <= baseCnt;
        else                  curCnt <= curCnt - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) tcQ <= 1'b0;
      else if (stb.masterClr) tcQ <= 1'b0;
      else if (wrCntHere) tcQ <= 1'b0;
      else if (stepOk && atWrap) tcQ <= 1'b1;
    end

    assign curAddrArr[c] = curAddr;
    assign curCntArr[c]  = curCnt;
    assign chanModes[c*MODE_W +: MODE_W] = modeQ;
    assign tcFlags[c]     = tcQ;
    assign chanToMem[c]   = !isCascade && xferType_e'(modeQ[1:0]) == TT_TOMEM;
    assign chanFromMem[c] = !isCascade && xferType_e'(modeQ[1:0]) == TT_FROMMEM;
  end

  always_comb begin
    logic [REG_W-1:0] sel;
    sel = stb.isCount ? curCntArr[stb.chan] : curAddrArr[stb.chan];
    if (!stb.regRd)      ioRdData = 8'h00;
    else if (stb.hiByte) ioRdData = sel[15:8];
    else                 ioRdData = sel[7:0];
  end
endmodule

// File: rtl/dmaChanRegs.sv
module dmaChanRegs
  import dmaRegPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] MODE_OFS = 'hB,
  parameter logic [ADDR_W-1:0] CLRPTR_OFS = 'hC,
  parameter logic [ADDR_W-1:0] MCLR_OFS = 'hD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  input  logic              xferAck,
  input  logic [1:0]        xferChan,
  output logic [23:0]       chanModes,
  output logic [3:0]        tcFlags,
  output logic [3:0]        chanToMem,
  output logic [3:0]        chanFromMem
);
  dmaStrobe_t stb;
  logic       bytePtr;

  dmaRegCtrl #(
    .ADDR_W(ADDR_W), .MODE_OFS(MODE_OFS), .CLRPTR_OFS(CLRPTR_OFS), .MCLR_OFS(MCLR_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
    .stb(stb), .bytePtr(bytePtr)
  );

  dmaRegData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .ioWrData(ioWrData),
    .xferAck(xferAck), .xferChan(xferChan), .ioRdData(ioRdData),
    .chanModes(chanModes), .tcFlags(tcFlags),
    .chanToMem(chanToMem), .chanFromMem(chanFromMem)
  );
endmodule

// File: rtl/dmaChanRegsChk.sv
module dmaChanRegsChk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] MODE_OFS = 'hB,
  parameter logic [ADDR_W-1:0] CLRPTR_OFS = 'hC,
  parameter logic [ADDR_W-1:0] MCLR_OFS = 'hD
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioWr,
  input logic              ioRd,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [7:0]        ioWrData,
  input logic              xferAck,
  input logic [23:0]       chanModes,
  input logic [3:0]        tcFlags,
  input logic              bytePtr
);
  localparam logic [ADDR_W-1:0] REG_SPAN = ADDR_W'(8);

  for (genvar c = 0; c < 4; c++) begin : gModeChk
    assert_mode_store_R1: assert property (@(posedge clk) disable iff (!rstN)
      (ioWr && ioAddr == MODE_OFS && ioWrData[1:0] == 2'(c))
        |=> chanModes[c*6 +: 6] == $past(ioWrData[7:2]));

    assert_cnt_wr_clears_tc_R11: assert property (@(posedge clk) disable iff (!rstN)
      (ioWr && ioAddr == ADDR_W'(2*c+1)) |=> !tcFlags[c]);
  end

  assert_ptr_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == CLRPTR_OFS) |=> !bytePtr);

  assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((ioWr || ioRd) && ioAddr < REG_SPAN) |=> bytePtr != $past(bytePtr));

  assert_tc_needs_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((tcFlags & ~$past(tcFlags)) != 4'b0) |-> $past(xferAck));

  assert_master_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == MCLR_OFS) |=> (chanModes == '0 && tcFlags == '0 && !bytePtr));
endmodule

bind dmaChanRegs dmaChanRegsChk #(
  .ADDR_W(ADDR_W), .MODE_OFS(MODE_OFS), .CLRPTR_OFS(CLRPTR_OFS), .MCLR_OFS(MCLR_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
  .ioWrData(ioWrData), .xferAck(xferAck), .chanModes(chanModes),
  .tcFlags(tcFlags), .bytePtr(bytePtr)
);

// File: tb/tb_dmaChanRegs.sv
module tb_dmaChanRegs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ioWr = 1'b0, ioRd = 1'b0, xferAck = 1'b0;
  logic [3:0] ioAddr = '0;
  logic [7:0] ioWrData = '0;
  logic [1:0] xferChan = '0;
  logic [7:0] ioRdData;
  logic [23:0] chanModes;
  logic [3:0] tcFlags, chanToMem, chanFromMem;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  dmaChanRegs dut (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .xferAck(xferAck), .xferChan(xferChan),
    .chanModes(chanModes), .tcFlags(tcFlags), .chanToMem(chanToMem), .chanFromMem(chanFromMem)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic op(input bit wr, input bit rd, input logic [3:0] a, input logic [7:0] d);
    ioWr = wr; ioRd = rd; ioAddr = a; ioWrData = d;
    @(posedge clk); #1;
    ioWr = 1'b0; ioRd = 1'b0;
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    op(1'b1, 1'b0, a, d);
  endtask

  task automatic rdExp(input logic [3:0] a, input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    op(1'b0, 1'b1, a, 8'h00);
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wrReg(a, v[7:0]);
    wrReg(a, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] a, input logic [15:0] e, input string tag);
    rdExp(a, e[7:0], tag);
    rdExp(a, e[15:8], tag);
  endtask

  task automatic ack(input logic [1:0] ch);
    xferAck = 1'b1; xferChan = ch;
    @(posedge clk); #1;
    xferAck = 1'b0;
  endtask

  task automatic clrPtr();
    wrReg(4'hC, 8'h5A);
  endtask

  // monitor: compare each read byte against the scoreboard
  always @(negedge clk) begin
    if (rstN && ioRd) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read act %h exp none", ioRdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(ioRdData == e, t, 32'(ioRdData), 32'(e));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk(chanModes == 24'h0, "R1 reset modes", 32'(chanModes), 0);
    chk(tcFlags == 4'h0, "R6 reset tc", 32'(tcFlags), 0);
    chk(chanToMem == 4'h0 && chanFromMem == 4'h0, "R9 reset dirs", {chanToMem, chanFromMem}, 0);
    rd16(4'h0, 16'h0000, "R4 reset ch0 addr");

    // R1 mode write to channel 2 only: single, incr, no autoinit, type 01
    wrReg(4'hB, 8'h46);
    chk(chanModes == (24'(6'b010001) << 12), "R1 ch2 mode only", 32'(chanModes), 32'(24'(6'b010001) << 12));
    chk(chanToMem == 4'b0100 && chanFromMem == 4'b0000, "R9 ch2 tomem", {chanToMem, chanFromMem}, 32'h40);

    // R4 program ch2 address and count
    clrPtr();
    wr16(4'h4, 16'h1234);
    wr16(4'h5, 16'h0002);
    rd16(4'h4, 16'h1234, "R4 ch2 addr readback");
    rd16(4'h5, 16'h0002, "R4 ch2 count readback");

    // R3 shared pointer: read count low, then address gives high byte
    clrPtr();
    rdExp(4'h5, 8'h02, "R3 count low first");
    rdExp(4'h4, 8'h12, "R3 addr high second");
    // R2 pointer clear after one access
    rdExp(4'h4, 8'h34, "R3 addr low third");
    clrPtr();
    rdExp(4'h4, 8'h34, "R2 low after clear");
    clrPtr();

    // R5 increment, R6 terminal count and stop
    ack(2'd2); ack(2'd2);
    chk(tcFlags == 4'b0000, "R6 no tc before wrap", 32'(tcFlags), 0);
    ack(2'd2);
    chk(tcFlags == 4'b0100, "R6 tc on wrap", 32'(tcFlags), 32'h4);
    rd16(4'h4, 16'h1237, "R5 ch2 addr incremented");
    rd16(4'h5, 16'hFFFF, "R6 ch2 count wrapped");
    ack(2'd2);
    rd16(4'h4, 16'h1237, "R6 stopped addr");
    rd16(4'h5, 16'hFFFF, "R6 stopped count");

    // R11 count write clears flag
    wrReg(4'h5, 8'h01);
    chk(tcFlags == 4'b0000, "R11 count write clears tc", 32'(tcFlags), 0);
    wrReg(4'h5, 8'h00);

    // R7 autoinit with decrement on ch1: demand, decr, auto, type 10
    wrReg(4'hB, 8'h39);
    chk(chanModes[11:6] == 6'b001110, "R1 ch1 mode", 32'(chanModes[11:6]), 32'h0E);
    chk(chanFromMem == 4'b0010 && chanToMem == 4'b0100, "R9 ch1 frommem", {chanToMem, chanFromMem}, 32'h42);
    wr16(4'h2, 16'h0100);
    wr16(4'h3, 16'h0001);
    ack(2'd1);
    rd16(4'h2, 16'h00FF, "R5 ch1 addr decremented");
    ack(2'd1);
    chk(tcFlags == 4'b0010, "R7 tc on autoinit wrap", 32'(tcFlags), 32'h2);
    rd16(4'h2, 16'h0100, "R7 addr reloaded");
    rd16(4'h3, 16'h0001, "R7 count reloaded");
    ack(2'd1);
    rd16(4'h2, 16'h00FF, "R7 keeps running addr");
    rd16(4'h3, 16'h0000, "R7 keeps running count");

    // R9 R10 cascade on ch3 with type 01
    wrReg(4'hB, 8'hC7);
    chk(chanToMem[3] == 1'b0 && chanFromMem[3] == 1'b0, "R9 cascade no dir", {chanToMem, chanFromMem}, 32'h42);
    ack(2'd3);
    chk(tcFlags[3] == 1'b0, "R10 cascade no tc", 32'(tcFlags), 32'h2);
    rd16(4'h6, 16'h0000, "R10 cascade addr unchanged");
    rd16(4'h7, 16'h0000, "R10 cascade count unchanged");

    // R9 illegal type on ch0
    wrReg(4'hB, 8'h0C);
    chk(chanModes[5:0] == 6'b000011, "R1 ch0 mode", 32'(chanModes[5:0]), 32'h03);
    chk(chanToMem[0] == 1'b0 && chanFromMem[0] == 1'b0, "R9 illegal no dir", {chanToMem, chanFromMem}, 32'h42);

    // R8 master clear with the pointer left on the high byte
    rdExp(4'h2, 8'hFF, "R3 ch1 low before clear");
    wrReg(4'hD, 8'h00);
    chk(chanModes == 24'h0, "R8 modes cleared", 32'(chanModes), 0);
    chk(tcFlags == 4'h0, "R8 tc cleared", 32'(tcFlags), 0);
    rd16(4'h2, 16'h00FF, "R8 pointer low and addr kept");
    ack(2'd1);
    rd16(4'h2, 16'h0100, "R8 direction back to increment");

    @(posedge clk); #1;
    chk(expQ.size() == 0, "R4 scoreboard drained", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule